// File: doc/BRIEF.md
# Register-to-Register ALU with Configurable Quirks

This block carries out the register-to-register arithmetic and logic group of a small 8-bit interpreter-style processor. It holds a bank of sixteen 8-bit registers, and the last register also serves as the flag register. A start strobe, together with an operation selector and two register indices X and Y, launches one operation. The block captures both operands, writes the result into register X and then writes the flag register.

Two static configuration bits pick between the behaviours of different interpreter generations:

- The shift-source bit selects whether a shift reads vY or shifts vX in place.
- The logic-flag bit selects whether the bitwise operations clear the flag register or leave it alone.

A simple load port and a combinational read port give the surrounding logic access to the bank.

Top module: `quirk_alu8`

## Requirements
- R1: A synchronous reset clears all sixteen registers to 0 and holds `done` and `illegal` low.
- R2: An accepted `start` makes `done` high for exactly one cycle, on the next cycle. Register contents change at the end of that cycle. A `start` that arrives while `done` is high is ignored.
- R3: Selector 0 copies vY into vX. Selectors 1, 2 and 3 write vX|vY, vX&vY and vX^vY into vX. Selector 0 never changes vF.
- R4: Selector 4 writes (vX+vY) mod 256 into vX, then writes 1 into vF on carry out and 0 otherwise.
- R5: Selector 5 writes vX−vY and selector 7 writes vY−vX, both modulo 256, into vX. vF then becomes 1 when there is no borrow and 0 when there is one. Equal operands count as no borrow.
- R6: Selector 6 shifts right by one, and vF receives the old bit 0. Selector 0xE shifts left by one, and vF receives the old bit 7.
- R7: When `shift_in_place` is 0, the shift source is vY, the result goes to vX and vY is left unchanged. When it is 1, vX shifts in place.
- R8: When `logic_keeps_flag` is 0, selectors 1 to 3 write 0 into vF after the result. When it is 1, vF keeps its value.
- R9: When X is 15, the flag value is written last, so vF ends up holding the flag rather than the result. In the logic-flag-keeping mode it holds the result.
- R10: Any selector other than 0–7 and 0xE leaves every register unchanged and pulses `illegal` together with `done`.
- R11: While no operation is writing back, `ld_en` writes `ld_data` into register `ld_idx`. `rd_data` always shows register `rd_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Launches one operation |
| op | input | 4 | Operation selector |
| x_idx | input | 4 | Destination and first operand index |
| y_idx | input | 4 | Second operand index |
| shift_in_place | input | 1 | 1: shifts read vX; 0: shifts read vY |
| logic_keeps_flag | input | 1 | 1: bitwise ops leave vF alone |
| ld_en | input | 1 | Register load strobe |
| ld_idx | input | 4 | Load target index |
| ld_data | input | 8 | Load value |
| rd_idx | input | 4 | Read index |
| rd_data | output | 8 | Contents of register rd_idx |
| done | output | 1 | Write-back cycle of an operation |
| illegal | output | 1 | Unsupported selector seen |

## Verification
The bench aims at the cases where the flag register is also the destination. A design that wrote the result after the flag would leave the sum or difference in vF instead of the carry or no-borrow bit. It checks subtraction with equal operands, where a design that took borrow as the flag condition would report 0 instead of 1. It runs shifts in both quirk modes and checks that vY survives a shift. A design that ignored the quirk bit would shift the wrong register. It also checks that illegal selectors and a second `start` during the write-back cycle change nothing, which a design that accepted every strobe or decoded loosely would fail.

// File: rtl/quirk_alu8.sv
module quirk_alu8 #(
  parameter int W    = 8,
  parameter int NREG = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic [3:0]              op,
  input  logic [$clog2(NREG)-1:0] x_idx,
  input  logic [$clog2(NREG)-1:0] y_idx,
  input  logic                    shift_in_place,
  input  logic                    logic_keeps_flag,
  input  logic                    ld_en,
  input  logic [$clog2(NREG)-1:0] ld_idx,
  input  logic [W-1:0]            ld_data,
  input  logic [$clog2(NREG)-1:0] rd_idx,
  output logic [W-1:0]            rd_data,
  output logic                    done,
  output logic                    illegal
);
  localparam int IW   = $clog2(NREG);
  localparam int FLAG = NREG - 1;

  logic [NREG-1:0][W-1:0] regs;
  logic          busy_q;
  logic [3:0]    op_q;
  logic [IW-1:0] x_q;
  logic [W-1:0]  a_q, b_q;

  logic [W-1:0]  res, flg, src;
  logic          wr_res, wr_flg, bad;
  logic [W:0]    sum;

  assign src = shift_in_place ? a_q : b_q;
  assign sum = {1'b0, a_q} + {1'b0, b_q};

  always_comb begin
    res    = '0;
    flg    = '0;
    wr_res = 1'b1;
    wr_flg = 1'b1;
    bad    = 1'b0;
    case (op_q)
      4'h0: begin res = b_q;       wr_flg = 1'b0; end
      4'h1: begin res = a_q | b_q; wr_flg = !logic_keeps_flag; end
      4'h2: begin res = a_q & b_q; wr_flg = !logic_keeps_flag; end
      4'h3: begin res = a_q ^ b_q; wr_flg = !logic_keeps_flag; end
      4'h4: begin res = sum[W-1:0]; flg[0] = sum[W]; end
      4'h5: begin res = a_q - b_q;  flg[0] = (a_q >= b_q); end
      4'h6: begin res = src >> 1;   flg[0] = src[0]; end
      4'h7: begin res = b_q - a_q;  flg[0] = (b_q >= a_q); end
      4'hE: begin res = src << 1;   flg[0] = src[W-1]; end
      default: begin wr_res = 1'b0; wr_flg = 1'b0; bad = 1'b1; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      regs   <= '0;
      busy_q <= 1'b0;
      op_q   <= '0;
      x_q    <= '0;
      a_q    <= '0;
      b_q    <= '0;
    end else begin
      busy_q <= start && !busy_q;
      if (start && !busy_q) begin
        op_q <= op;
        x_q  <= x_idx;
        a_q  <= regs[x_idx];
        b_q  <= regs[y_idx];
      end
      if (busy_q) begin
        if (wr_res) regs[x_q]  <= res;
        if (wr_flg) regs[FLAG] <= flg;
      end else if (ld_en) begin
        regs[ld_idx] <= ld_data;
      end
    end
  end

  assign rd_data = regs[rd_idx];
  assign done    = busy_q;
  assign illegal = busy_q && bad;

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (regs == '0) && !done && !illegal);
  // R2
  start_done_chk: assert property (@(posedge clk) disable iff (rst) (start && !done) |=> done);
  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  // R10
  illegal_hold_chk: assert property (@(posedge clk) disable iff (rst) illegal |=> $stable(regs));
  // R10
  illegal_in_done_chk: assert property (@(posedge clk) disable iff (rst) illegal |-> done);
  // R9
  flag_last_chk: assert property (@(posedge clk) disable iff (rst)
    (done && wr_flg) |=> regs[FLAG] == $past(flg));
endmodule

// File: tb/quirk_alu8_tb_top.sv
module quirk_alu8_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst, start, shift_in_place, logic_keeps_flag, ld_en;
  logic [3:0] op, x_idx, y_idx, ld_idx, rd_idx;
  logic [7:0] ld_data, rd_data;
  logic done, illegal;
  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  quirk_alu8 dut_i (
    .clk(clk), .rst(rst), .start(start), .op(op), .x_idx(x_idx), .y_idx(y_idx),
    .shift_in_place(shift_in_place), .logic_keeps_flag(logic_keeps_flag),
    .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data), .rd_idx(rd_idx),
    .rd_data(rd_data), .done(done), .illegal(illegal)
  );

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic peek(string tag, logic [3:0] idx, logic [7:0] exp);
    rd_idx = idx;
    #1;
    check(tag, rd_data, exp);
  endtask

  task automatic load(logic [3:0] idx, logic [7:0] val);
    @(negedge clk);
    ld_en = 1'b1; ld_idx = idx; ld_data = val;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic run(logic [3:0] o, logic [3:0] x, logic [3:0] y, logic exp_ill);
    @(negedge clk);
    start = 1'b1; op = o; x_idx = x; y_idx = y;
    @(negedge clk);
    start = 1'b0;
    check("R2 done", {7'd0, done}, 8'd1);
    check("R10 illegal", {7'd0, illegal}, {7'd0, exp_ill});
    @(negedge clk);
    check("R2 done drop", {7'd0, done}, 8'd0);
  endtask

  task automatic t_reset;
    for (int i = 0; i < 16; i++) peek("R1 reg clear", 4'(i), 8'h00);
    check("R1 done low", {7'd0, done}, 8'd0);
    check("R1 illegal low", {7'd0, illegal}, 8'd0);
  endtask

  task automatic t_load;
    load(4'd9, 8'hA5);
    peek("R11 load", 4'd9, 8'hA5);
  endtask

  task automatic t_logic;
    logic_keeps_flag = 1'b0;
    load(4'd1, 8'hC3); load(4'd2, 8'h5A); load(4'hF, 8'h07);
    run(4'h1, 4'd1, 4'd2, 1'b0);
    peek("R3 or", 4'd1, 8'hDB);
    peek("R8 or clears vF", 4'hF, 8'h00);
    load(4'hF, 8'h07);
    logic_keeps_flag = 1'b1;
    run(4'h2, 4'd1, 4'd2, 1'b0);
    peek("R3 and", 4'd1, 8'h5A);
    peek("R8 and keeps vF", 4'hF, 8'h07);
    run(4'h3, 4'd1, 4'd2, 1'b0);
    peek("R3 xor", 4'd1, 8'h00);
    peek("R8 xor keeps vF", 4'hF, 8'h07);
    logic_keeps_flag = 1'b0;
    run(4'h0, 4'd3, 4'd2, 1'b0);
    peek("R3 mov", 4'd3, 8'h5A);
    peek("R3 mov leaves vF", 4'hF, 8'h07);
  endtask

  task automatic t_add;
    load(4'd4, 8'hF0); load(4'd5, 8'h20);
    run(4'h4, 4'd4, 4'd5, 1'b0);
    peek("R4 add wrap", 4'd4, 8'h10);
    peek("R4 carry 1", 4'hF, 8'h01);
    run(4'h4, 4'd4, 4'd5, 1'b0);
    peek("R4 add", 4'd4, 8'h30);
    peek("R4 carry 0", 4'hF, 8'h00);
  endtask

  task automatic t_sub;
    load(4'd6, 8'h30); load(4'd7, 8'h10);
    run(4'h5, 4'd6, 4'd7, 1'b0);
    peek("R5 sub", 4'd6, 8'h20);
    peek("R5 no borrow", 4'hF, 8'h01);
    load(4'd7, 8'h30);
    run(4'h5, 4'd6, 4'd7, 1'b0);
    peek("R5 sub wrap", 4'd6, 8'hF0);
    peek("R5 borrow", 4'hF, 8'h00);
    load(4'd8, 8'h05); load(4'd9, 8'h03);
    run(4'h7, 4'd8, 4'd9, 1'b0);
    peek("R5 rsub", 4'd8, 8'hFE);
    peek("R5 rsub borrow", 4'hF, 8'h00);
    load(4'hA, 8'h40); load(4'hB, 8'h40);
    run(4'h5, 4'hA, 4'hB, 1'b0);
    peek("R5 equal", 4'hA, 8'h00);
    peek("R5 equal no borrow", 4'hF, 8'h01);
  endtask

  task automatic t_shift;
    shift_in_place = 1'b0;
    load(4'hC, 8'h00); load(4'hD, 8'h81);
    run(4'h6, 4'hC, 4'hD, 1'b0);
    peek("R7 shr from vY", 4'hC, 8'h40);
    peek("R6 shr flag", 4'hF, 8'h01);
    peek("R7 vY kept", 4'hD, 8'h81);
    run(4'hE, 4'hC, 4'hD, 1'b0);
    peek("R7 shl from vY", 4'hC, 8'h02);
    peek("R6 shl flag", 4'hF, 8'h01);
    shift_in_place = 1'b1;
    run(4'h6, 4'hC, 4'hD, 1'b0);
    peek("R7 shr in place", 4'hC, 8'h01);
    peek("R6 shr flag 0", 4'hF, 8'h00);
    run(4'hE, 4'hC, 4'hD, 1'b0);
    peek("R7 shl in place", 4'hC, 8'h02);
    peek("R6 shl flag 0", 4'hF, 8'h00);
    shift_in_place = 1'b0;
  endtask

  task automatic t_flag_dest;
    load(4'hF, 8'h10); load(4'd1, 8'h20);
    run(4'h4, 4'hF, 4'd1, 1'b0);
    peek("R9 add into vF", 4'hF, 8'h00);
    load(4'hF, 8'h50);
    run(4'h5, 4'hF, 4'd1, 1'b0);
    peek("R9 sub into vF", 4'hF, 8'h01);
    load(4'hF, 8'h0F);
    logic_keeps_flag = 1'b1;
    run(4'h1, 4'hF, 4'd1, 1'b0);
    peek("R9 or into vF kept", 4'hF, 8'h2F);
    logic_keeps_flag = 1'b0;
  endtask

  task automatic t_illegal;
    load(4'd1, 8'h11); load(4'd2, 8'h22); load(4'hF, 8'h33);
    run(4'h8, 4'd1, 4'd2, 1'b1);
    peek("R10 v1 kept", 4'd1, 8'h11);
    peek("R10 v2 kept", 4'd2, 8'h22);
    peek("R10 vF kept", 4'hF, 8'h33);
    run(4'hF, 4'd1, 4'd2, 1'b1);
    peek("R10 v1 kept F", 4'd1, 8'h11);
    peek("R10 vF kept F", 4'hF, 8'h33);
  endtask

  task automatic t_busy;
    load(4'd1, 8'h01); load(4'd2, 8'h01);
    @(negedge clk);
    start = 1'b1; op = 4'h4; x_idx = 4'd1; y_idx = 4'd2;
    @(negedge clk);
    check("R2 done busy", {7'd0, done}, 8'd1);
    @(negedge clk);
    start = 1'b0;
    check("R2 second start ignored", {7'd0, done}, 8'd0);
    peek("R2 single add", 4'd1, 8'h02);
  endtask

  initial begin
    rst = 1'b1; start = 1'b0; op = '0; x_idx = '0; y_idx = '0;
    shift_in_place = 1'b0; logic_keeps_flag = 1'b0;
    ld_en = 1'b0; ld_idx = '0; ld_data = '0; rd_idx = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_load();
    t_logic();
    t_add();
    t_sub();
    t_shift();
    t_flag_dest();
    t_illegal();
    t_busy();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule